// File: doc/BRIEF.md
# DRAM Page-Mode Burst Read Controller

This block sequences fast page-mode reads from a DRAM bank on a 32-bit data bus. A read request brings a byte address, a burst flag and the current bank settings. The controller opens the row once and then strobes up to four columns back to back. The first column is the requested word, and the following columns wrap around inside the aligned four-word group. After the last column it releases the row strobe for a programmable precharge time and only then takes the next request. With every wait setting at zero, a burst returns its four words on a 2-1-1-1 clock profile.

The bank settings are static inputs. They choose whether page bursts are allowed, and whether the controller multiplexes row and column onto the address pins itself or leaves that to external logic. In the external case the controller tells that logic when to switch through a column-select output. The settings also give an optional extra row-to-column clock, separate wait counts for the first and later beats, a one- or two-clock precharge, and the bus width. On byte and halfword buses the two low address bits appear on two byte-enable pins. A bus-error input cuts an access short at any point while the row is open.

Top module: `dram_burst_rd_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, and until the next request, the block holds `req_ready`=1, `mem_ras_n`=1, `mem_cas_n`=4'hF, `mem_oe_n`=1, `mem_we_n`=1, `mem_wbe_n`=4'hF, `rd_valid`=0 and `rd_done`=0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle, `mem_ras_n` is low with `mem_amux_cas`=0 and `mem_cas_n`=4'hF for 1+`cfg_rcd` cycles. Each beat then holds `mem_cas_n`=4'h0 and `mem_amux_cas`=1 for 1+wait cycles. The wait is `cfg_first_wait` for beat 0 and `cfg_burst_wait` for later beats, so all-zero settings give two clocks for the first word and one for each later word.
- R3: In the last cycle of each beat, `mem_dq` is captured. It appears on `rd_data` with `rd_valid`=1 for exactly the next cycle.
- R4: A burst request with `cfg_page_mode`=1 returns four beats. Beat k addresses the word whose index within the aligned four-word group is (`req_addr[3:2]` + k) mod 4.
- R5: With `cfg_ext_mux`=0, the low MUX_W pins of `mem_a` carry the row `req_addr[2*MUX_W+1:MUX_W+2]` while only the row strobe is active. During the column strobes they carry the word-address bits `req_addr[MUX_W+1:2]` with the beat's word index in the two lowest pins. The upper pins always carry `req_addr[ADDR_W-1:MUX_W+2]`.
- R6: With `cfg_ext_mux`=1, `mem_a` carries the full word address of the current beat (`req_addr[ADDR_W-1:4]` followed by the beat's word index), and does not change between the row cycle and the first column cycle.
- R7: `mem_wbe_n[1:0]` is always 2'b11. During an access, if `cfg_bus_width` is 2'b00 (byte) or 2'b01 (halfword), `mem_wbe_n[2]`=`req_addr[1]` and `mem_wbe_n[3]`=`req_addr[0]`. For widths 2'b10 and 2'b11 (word) both pins are 1.
- R8: `mem_we_n` stays 1, and `mem_oe_n` is low in exactly the cycles in which the column strobes are low.
- R9: `rd_done` is 1 for one cycle, the cycle after the last beat's `rd_valid`.
- R10: After the last beat, `mem_ras_n` and `mem_cas_n` are all high for 1+`cfg_precharge` cycles, and `req_ready` returns in the cycle after that.
- R11: A request with `req_burst`=0, or any request while `cfg_page_mode`=0, performs only one beat and then precharges.
- R12: If `bus_err` is 1 at an edge while the row is open, the next cycle has `mem_ras_n`=1 and `mem_cas_n`=4'hF. No further `rd_valid` and no `rd_done` follow, and `req_ready` returns after the precharge time.
- R13: `req_valid` is ignored while `req_ready` is 0. Such a request opens no row, either during the access or after it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_addr | input | ADDR_W | Byte address of the target word |
| req_burst | input | 1 | Request a four-word burst |
| cfg_page_mode | input | 1 | Allow page-mode bursts |
| cfg_ext_mux | input | 1 | Row/column multiplexing done outside |
| cfg_bus_width | input | 2 | 00 byte, 01 halfword, 1x word |
| cfg_rcd | input | 1 | One extra row-to-column clock |
| cfg_first_wait | input | WAIT_W | Extra clocks on the first beat |
| cfg_burst_wait | input | WAIT_W | Extra clocks on each later beat |
| cfg_precharge | input | 1 | One extra precharge clock |
| bus_err | input | 1 | Abort the open access |
| rd_valid | output | 1 | Read word valid strobe |
| rd_data | output | DATA_W | Read word |
| rd_done | output | 1 | Access finished normally |
| mem_a | output | ADDR_W-2 | DRAM word address pins |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 4 | Column strobes per byte lane, active low |
| mem_oe_n | output | 1 | DRAM output enable, active low |
| mem_we_n | output | 1 | DRAM write enable, active low |
| mem_amux_cas | output | 1 | Column phase indication for external mux |
| mem_wbe_n | output | 4 | Byte enables, upper two double as low address bits |
| mem_dq | input | DATA_W | DRAM read data |

## Verification
The hardest case to reach from the ports is a bus error that lands in the middle of an open page. A burst must already have returned some words, the column strobes must still be low, and the precharge must then finish without a stray valid or done. The bench raises `bus_err` right after the first word comes back and follows the strobes, the valid output and `req_ready` cycle by cycle. A second hard case is a request held high for a whole burst and dropped one cycle before the controller goes idle. That test shows a busy-time request is never captured late.

// File: rtl/dram_rd_pkg.sv
// Package: shared state encoding and bus-width codes for the DRAM burst
// read controller. Assumes nothing beyond a single clock domain.
package dram_rd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ROW  = 2'd1,
        ST_COL  = 2'd2,
        ST_PRE  = 2'd3
    } rd_state_t;

    localparam logic [1:0] BW_BYTE = 2'b00;
    localparam logic [1:0] BW_HALF = 2'b01;
    localparam int         BEATS   = 4;
endpackage

// File: rtl/dram_phase_timer.sv
// Module: down-counter that times one phase of a DRAM access.
// A load sets the remaining extra cycles; 'expired' is high when none remain.
// Assumes the owner reloads it at every phase change.
module dram_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    // Count the remaining extra cycles of the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - CNT_W'(1);
    end

    assign expired = (cnt == '0);

    // A loaded count is held exactly, which sets every phase length (R2).
    assert_load_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val)));

    // Without a load the count falls by one per clock, timing the precharge (R10).
    assert_count_down_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));
endmodule

// File: rtl/dram_addr_drive.sv
// Module: drives the DRAM address pins and byte enables from the latched
// request address and the current beat. Internal mux puts the row on the
// low MUX_W pins during the row phase; external mux always drives the word
// address. Assumes 2*MUX_W+2 <= ADDR_W.
module dram_addr_drive #(
    parameter int ADDR_W = 26,
    parameter int MUX_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [1:0]        beat_idx,
    input  logic              row_phase,
    input  logic              col_phase,
    input  logic              busy,
    input  logic              ext_mux,
    input  logic [1:0]        bus_width,
    output logic [ADDR_W-3:0] mem_a,
    output logic [3:0]        mem_wbe_n
);
    import dram_rd_pkg::*;

    localparam int WA_W   = ADDR_W - 2;
    localparam int ROW_LO = MUX_W + 2;
    localparam int ROW_HI = 2 * MUX_W + 1;

    logic [WA_W-1:0] beat_word;
    logic            narrow;

    assign beat_word = {addr_q[ADDR_W-1:4], addr_q[3:2] + beat_idx};
    assign narrow    = (bus_width == BW_BYTE) || (bus_width == BW_HALF);

    // Pick the row or the column/full word for the address pins.
    always_comb begin
        if (row_phase && !ext_mux)
            mem_a = {addr_q[ADDR_W-1:ROW_LO], addr_q[ROW_HI:ROW_LO]};
        else
            mem_a = beat_word;
    end

    // Byte enables: low pair held high, upper pair carries low address bits on narrow buses.
    always_comb begin
        mem_wbe_n = 4'hF;
        if (busy && narrow)
            mem_wbe_n[3:2] = {addr_q[0], addr_q[1]};
    end

    // External mux: the pins stay still across the row-to-column step (R6).
    assert_ext_addr_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mux && col_phase && $past(row_phase)) |-> $stable(mem_a));
endmodule

// File: rtl/dram_burst_rd_ctrl.sv
// Module: page-mode DRAM burst read controller (top). One row activation,
// up to four column beats starting at the target word, then precharge.
// Assumes the cfg_* inputs stay constant during an access and mem_dq is
// valid in the last cycle of each beat.
module dram_burst_rd_ctrl #(
    parameter int ADDR_W = 26,
    parameter int MUX_W  = 11,
    parameter int DATA_W = 32,
    parameter int WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_burst,
    input  logic              cfg_page_mode,
    input  logic              cfg_ext_mux,
    input  logic [1:0]        cfg_bus_width,
    input  logic              cfg_rcd,
    input  logic [WAIT_W-1:0] cfg_first_wait,
    input  logic [WAIT_W-1:0] cfg_burst_wait,
    input  logic              cfg_precharge,
    input  logic              bus_err,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_done,
    output logic [ADDR_W-3:0] mem_a,
    output logic              mem_ras_n,
    output logic [3:0]        mem_cas_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_amux_cas,
    output logic [3:0]        mem_wbe_n,
    input  logic [DATA_W-1:0] mem_dq
);
    import dram_rd_pkg::*;

    localparam logic [1:0] LAST_BEAT = 2'(BEATS - 1);

    rd_state_t         state, state_nxt;
    logic [ADDR_W-1:0] addr_q;
    logic              burst_q;
    logic [1:0]        beat_q;
    logic              tmr_load, tmr_expired;
    logic [WAIT_W-1:0] tmr_val;
    logic              beat_end, last_beat;
    logic              rd_valid_q, rd_last_q, done_q;
    logic [DATA_W-1:0] rd_data_q;
    logic              row_phase, col_phase;

    assign last_beat = !burst_q || (beat_q == LAST_BEAT);
    assign row_phase = (state == ST_ROW);
    assign col_phase = (state == ST_COL);

    dram_phase_timer #(.CNT_W(WAIT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    // Next state, phase timer loads and beat-end detection.
    always_comb begin
        state_nxt = state;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        beat_end  = 1'b0;
        case (state)
            ST_IDLE: if (req_valid) begin
                state_nxt = ST_ROW;
                tmr_load  = 1'b1;
                tmr_val   = WAIT_W'(cfg_rcd);
            end
            ST_ROW: if (bus_err) begin
                state_nxt = ST_PRE;
                tmr_load  = 1'b1;
                tmr_val   = WAIT_W'(cfg_precharge);
            end else if (tmr_expired) begin
                state_nxt = ST_COL;
                tmr_load  = 1'b1;
                tmr_val   = cfg_first_wait;
            end
            ST_COL: if (bus_err) begin
                state_nxt = ST_PRE;
                tmr_load  = 1'b1;
                tmr_val   = WAIT_W'(cfg_precharge);
            end else if (tmr_expired) begin
                beat_end = 1'b1;
                tmr_load = 1'b1;
                if (last_beat) begin
                    state_nxt = ST_PRE;
                    tmr_val   = WAIT_W'(cfg_precharge);
                end else begin
                    tmr_val   = cfg_burst_wait;
                end
            end
            default: if (tmr_expired) state_nxt = ST_IDLE;
        endcase
    end

    // State register and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            addr_q  <= '0;
            burst_q <= 1'b0;
            beat_q  <= '0;
        end else begin
            state <= state_nxt;
            if (state == ST_IDLE && req_valid) begin
                addr_q  <= req_addr;
                burst_q <= req_burst && cfg_page_mode;
                beat_q  <= '0;
            end else if (beat_end && !last_beat) begin
                beat_q  <= beat_q + 2'd1;
            end
        end
    end

    // Read data capture with one-cycle valid and a trailing done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            rd_last_q  <= 1'b0;
            done_q     <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= beat_end;
            rd_last_q  <= beat_end && last_beat;
            done_q     <= rd_last_q;
            if (beat_end)
                rd_data_q <= mem_dq;
        end
    end

    dram_addr_drive #(.ADDR_W(ADDR_W), .MUX_W(MUX_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_q    (addr_q),
        .beat_idx  (beat_q),
        .row_phase (row_phase),
        .col_phase (col_phase),
        .busy      (state != ST_IDLE),
        .ext_mux   (cfg_ext_mux),
        .bus_width (cfg_bus_width),
        .mem_a     (mem_a),
        .mem_wbe_n (mem_wbe_n)
    );

    // One column strobe per byte lane, all active for a read.
    for (genvar g = 0; g < 4; g++) begin : g_cas_lane
        assign mem_cas_n[g] = !col_phase;
    end

    assign req_ready    = (state == ST_IDLE);
    assign mem_ras_n    = !(row_phase || col_phase);
    assign mem_oe_n     = !col_phase;
    assign mem_we_n     = 1'b1;
    assign mem_amux_cas = col_phase;
    assign rd_valid     = rd_valid_q;
    assign rd_data      = rd_data_q;
    assign rd_done      = done_q;

    // A bus error while the row is open drops every strobe on the next cycle (R12).
    assert_err_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && !mem_ras_n) |=> (mem_ras_n && mem_cas_n == 4'hF));

    // The row only opens on an accepted request (R13).
    assert_row_needs_accept_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ras_n) |-> $past(req_valid && req_ready));

    // Valid data only follows a cycle with the column strobes low (R3).
    assert_valid_after_cas_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(mem_cas_n == 4'h0));

    // Done only follows a valid beat (R9).
    assert_done_after_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> $past(rd_valid));
endmodule

// File: tb/dram_burst_rd_ctrl_bench.sv
module dram_burst_rd_ctrl_bench;
    localparam int ADDR_W = 26;
    localparam int MUX_W  = 11;
    localparam int DATA_W = 32;
    localparam int WAIT_W = 2;
    localparam int ROW_LO = MUX_W + 2;
    localparam int ROW_HI = 2 * MUX_W + 1;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n, req_valid, req_ready, req_burst;
    logic [ADDR_W-1:0] req_addr;
    logic              cfg_page_mode, cfg_ext_mux, cfg_rcd, cfg_precharge, bus_err;
    logic [1:0]        cfg_bus_width;
    logic [WAIT_W-1:0] cfg_first_wait, cfg_burst_wait;
    logic              rd_valid, rd_done;
    logic [DATA_W-1:0] rd_data, mem_dq;
    logic [ADDR_W-3:0] mem_a;
    logic              mem_ras_n, mem_oe_n, mem_we_n, mem_amux_cas;
    logic [3:0]        mem_cas_n, mem_wbe_n;

    // DRAM model: drives a tag plus the address pins while output is enabled.
    assign mem_dq = mem_oe_n ? '0 : {8'hA5, mem_a};

    dram_burst_rd_ctrl #(.ADDR_W(ADDR_W), .MUX_W(MUX_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W))
    u_dram_burst_rd_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_burst(req_burst), .cfg_page_mode(cfg_page_mode),
        .cfg_ext_mux(cfg_ext_mux), .cfg_bus_width(cfg_bus_width), .cfg_rcd(cfg_rcd),
        .cfg_first_wait(cfg_first_wait), .cfg_burst_wait(cfg_burst_wait),
        .cfg_precharge(cfg_precharge), .bus_err(bus_err), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_done(rd_done), .mem_a(mem_a), .mem_ras_n(mem_ras_n),
        .mem_cas_n(mem_cas_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_amux_cas(mem_amux_cas), .mem_wbe_n(mem_wbe_n), .mem_dq(mem_dq)
    );

    int errors = 0;
    int checks = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              burst;
        logic              page;
        logic              ext;
        logic [1:0]        bw;
        logic [1:0]        fw;
        logic [1:0]        bwt;
        logic              rcd;
        logic              pre;
        logic [3:0]        v0;      // expected cycle of the first valid
        logic [2:0]        nbeats;  // expected number of beats
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{26'h2ABCDE4, 1'b1, 1'b1, 1'b0, 2'b10, 2'd0, 2'd0, 1'b0, 1'b0, 4'd2, 3'd4},
        '{26'h13579BC, 1'b1, 1'b1, 1'b1, 2'b00, 2'd1, 2'd1, 1'b1, 1'b1, 4'd4, 3'd4},
        '{26'h0F0F0F2, 1'b0, 1'b1, 1'b0, 2'b01, 2'd2, 2'd0, 1'b0, 1'b1, 4'd4, 3'd1},
        '{26'h3FFFFF8, 1'b1, 1'b0, 1'b0, 2'b00, 2'd0, 2'd2, 1'b1, 1'b0, 4'd3, 3'd1},
        '{26'h2000007, 1'b1, 1'b1, 1'b0, 2'b01, 2'd3, 2'd3, 1'b0, 1'b1, 4'd5, 3'd4},
        '{26'h1C3A5F0, 1'b1, 1'b1, 1'b1, 2'b10, 2'd0, 2'd1, 1'b0, 1'b0, 4'd2, 3'd4}
    };

    task automatic apply_cfg(input vec_t v);
        cfg_page_mode  = v.page;
        cfg_ext_mux    = v.ext;
        cfg_bus_width  = v.bw;
        cfg_first_wait = v.fw;
        cfg_burst_wait = v.bwt;
        cfg_rcd        = v.rcd;
        cfg_precharge  = v.pre;
        req_addr       = v.addr;
        req_burst      = v.burst;
    endtask

    // Present a request, then follow the access cycle by cycle (sample 0 = first row cycle).
    task automatic run_vec(input vec_t v);
        logic [ADDR_W-1:0] a;
        logic [ADDR_W-3:0] a0, exp_a;
        logic [DATA_W-1:0] exp_d;
        logic [3:0]        exp_wbe;
        logic [1:0]        w;
        int n, v0, step, vlast, nb, done_at, ready_at, exp_c;
        string tag;
        a = v.addr; n = int'(v.nbeats); v0 = int'(v.v0); step = int'(v.bwt) + 1;
        vlast = v0 + (n - 1) * step; nb = 0; done_at = -1; ready_at = -1;
        @(posedge clk); #1;
        apply_cfg(v);
        req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        // Row cycle.
        chk(mem_ras_n == 1'b0 && mem_cas_n == 4'hF && mem_amux_cas == 1'b0, "R2 row phase",
            {mem_ras_n, mem_cas_n, mem_amux_cas}, 6'b0_1111_0);
        if (v.ext) begin
            exp_a = a[ADDR_W-1:2];
            chk(mem_a == exp_a, "R6 row address", mem_a, exp_a);
        end else begin
            exp_a = {a[ADDR_W-1:ROW_LO], a[ROW_HI:ROW_LO]};
            chk(mem_a == exp_a, "R5 row address", mem_a, exp_a);
        end
        exp_wbe = v.bw[1] ? 4'hF : {a[0], a[1], 2'b11};
        chk(mem_wbe_n == exp_wbe, "R7 byte enables", mem_wbe_n, exp_wbe);
        a0 = mem_a;
        for (int c = 1; c <= vlast + int'(v.pre) + 3; c++) begin
            @(posedge clk); #1;
            if (c <= int'(v.rcd))
                chk(mem_ras_n == 1'b0 && mem_cas_n == 4'hF, "R2 row-to-column delay",
                    {mem_ras_n, mem_cas_n}, 5'b0_1111);
            if (c == 1 + int'(v.rcd)) begin
                chk(mem_cas_n == 4'h0 && mem_oe_n == 1'b0 && mem_amux_cas == 1'b1,
                    "R2 first column", {mem_cas_n, mem_oe_n, mem_amux_cas}, 6'b0000_0_1);
                chk(mem_we_n == 1'b1, "R8 write enable", mem_we_n, 1'b1);
                exp_a = {a[ADDR_W-1:4], a[3:2]};
                chk(mem_a == exp_a, "R5 column address", mem_a, exp_a);
                if (v.ext) chk(mem_a == a0, "R6 no switch at column", mem_a, a0);
            end
            if (rd_valid) begin
                exp_c = v0 + nb * step;
                chk(c == exp_c, "R3 valid timing", c, exp_c);
                w = a[3:2] + 2'(nb);
                exp_d = {8'hA5, a[ADDR_W-1:4], w};
                chk(rd_data == exp_d, "R4 beat data order", rd_data, exp_d);
                nb++;
            end
            if (rd_done && done_at < 0) done_at = c;
            if (req_ready && ready_at < 0) ready_at = c;
            if (c == vlast)
                chk(mem_ras_n == 1'b1 && mem_cas_n == 4'hF && mem_oe_n == 1'b1,
                    "R10 precharge start", {mem_ras_n, mem_cas_n, mem_oe_n}, 6'b1_1111_1);
        end
        tag = (n == 1) ? "R11 beat count" : "R4 beat count";
        chk(nb == n, tag, nb, n);
        chk(done_at == vlast + 1, "R9 done timing", done_at, vlast + 1);
        chk(ready_at == vlast + int'(v.pre) + 1, "R10 ready return", ready_at,
            vlast + int'(v.pre) + 1);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; bus_err = 1'b0;
        apply_cfg(VECS[0]);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state.
        chk(req_ready == 1'b1 && mem_ras_n == 1'b1 && mem_cas_n == 4'hF, "R1 ready and strobes",
            {req_ready, mem_ras_n, mem_cas_n}, 6'b1_1_1111);
        chk(mem_oe_n == 1'b1 && mem_we_n == 1'b1 && mem_wbe_n == 4'hF, "R1 enables",
            {mem_oe_n, mem_we_n, mem_wbe_n}, 6'b1_1_1111);
        chk(rd_valid == 1'b0 && rd_done == 1'b0, "R1 valid and done", {rd_valid, rd_done}, 2'b00);

        // Table of configurations.
        for (int i = 0; i < 6; i++) run_vec(VECS[i]);

        // R12: bus error right after the first word of a burst.
        begin
            int nv = 0, dn = 0, rdy = -1;
            @(posedge clk); #1;
            apply_cfg(VECS[0]);
            req_valid = 1'b1;
            @(posedge clk); #1;
            req_valid = 1'b0;
            for (int c = 1; c <= 9; c++) begin
                @(posedge clk); #1;
                if (c == 3) begin
                    chk(mem_ras_n == 1'b1 && mem_cas_n == 4'hF, "R12 strobes released",
                        {mem_ras_n, mem_cas_n}, 5'b1_1111);
                    bus_err = 1'b0;
                end
                if (c >= 3 && rd_valid) nv++;
                if (rd_done) dn++;
                if (req_ready && rdy < 0) rdy = c;
                if (c == 2) bus_err = 1'b1;
            end
            chk(nv == 0, "R12 no valid after error", nv, 0);
            chk(dn == 0, "R12 no done after error", dn, 0);
            chk(rdy == 4, "R12 ready after precharge", rdy, 4);
        end

        // R13: a request held during a burst is not captured.
        begin
            int nv = 0, opened = 0;
            @(posedge clk); #1;
            apply_cfg(VECS[0]);
            req_valid = 1'b1;
            @(posedge clk); #1;
            req_addr = 26'h0000100;
            for (int c = 1; c <= 9; c++) begin
                @(posedge clk); #1;
                if (c == 1) chk(req_ready == 1'b0, "R13 busy not ready", req_ready, 1'b0);
                if (rd_valid) nv++;
                if (c >= 6 && mem_ras_n == 1'b0) opened++;
                if (c == 5) req_valid = 1'b0;
            end
            chk(nv == 4, "R13 burst completes", nv, 4);
            chk(opened == 0, "R13 no late row open", opened, 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R2: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule